// File: doc/BRIEF.md
# Event Status Register Hierarchy

The block keeps a small set of sticky event registers for a measurement instrument and folds them into one operation status word. Four sources report events: acquisition, clock recovery, limit test and jitter analysis. Every source signal is first synchronised to the block clock. The qualifying edge of the signal then sets a bit in the event register of that source. The bit stays set until the host reads that register. That read returns the current value and clears it.

The host also writes one enable mask for each event register. The operation status word is driven combinationally. Each of its summary bits is the OR of one event register ANDed with its enable mask. Limit test completion drives a second summary bit as well, and the acquisition enable gates that bit. Clock recovery reports the loop lock status in both directions and the signal detect of two receivers in both directions. A relock that the host starts while the loop is locked does not report lock events.

Top module: `evstat_bank`

## Requirements
- R1: A rising edge on `acq_done` sets bit 0 of the acquisition event register (address 0). The bit is visible in the third clock cycle after the input changes.
- R2: A rising edge on `cr_locked` sets bit 1 of the clock recovery event register (address 1). A falling edge on `cr_locked` sets bit 0 of that register.
- R3: In the clock recovery event register, a falling edge on `rx1_sig` sets bit 2 and a rising edge sets bit 3. A falling edge on `rx2_sig` sets bit 4 and a rising edge sets bit 5. A steady level sets nothing.
- R4: In the limit test event register (address 2), `lt_done` sets bit 0 and `lt_fail` sets bit 1, both on a rising edge. In the jitter event register (address 3), rising edges on `jit_edge_fail`, `jit_sync_lost` and `jit_autoscale` set bits 0, 1 and 2.
- R5: An event bit stays set until its register is read. A read with `rd`=1 returns the value on `rdata` in the same cycle and clears the register. An event that is captured on the clearing edge stays set.
- R6: The enable masks are at addresses 4 (acquisition, 1 bit), 5 (clock recovery, 6 bits), 6 (limit test, 2 bits) and 7 (jitter, 3 bits). Each is written with `wr` and read back zero-extended, and a read does not clear it. A write to addresses 0 to 3 has no effect.
- R7: In `opstat`, bit 7 is set when any clock recovery event bit is set and enabled. Bit 8 does the same for limit test and bit 12 for jitter. Every other bit except bit 9 is 0.
- R8: `opstat` bit 9 is set when bit 0 of the acquisition enable is 1 and either the acquisition event bit 0 or the limit test event bit 0 is set.
- R9: A `relock_req` pulse while the synchronised lock status is high suppresses clock recovery bits 0 and 1 until a `relock_done` pulse. A `relock_req` while unlocked suppresses nothing.
- R10: After reset, all event registers, all enable masks and `opstat` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| acq_done | input | 1 | Acquisition completion criteria met (asynchronous) |
| cr_locked | input | 1 | Clock recovery locked or trigger captured, level (asynchronous) |
| rx1_sig | input | 1 | Receiver one signal detect, level (asynchronous) |
| rx2_sig | input | 1 | Receiver two signal detect, level (asynchronous) |
| lt_done | input | 1 | Limit test complete (asynchronous) |
| lt_fail | input | 1 | Limit test failed (asynchronous) |
| jit_edge_fail | input | 1 | Jitter edge characterization failed (asynchronous) |
| jit_sync_lost | input | 1 | Jitter pattern synchronization lost (asynchronous) |
| jit_autoscale | input | 1 | Jitter autoscale required (asynchronous) |
| relock_req | input | 1 | Host relock request pulse (synchronous) |
| relock_done | input | 1 | Relock finished pulse (synchronous) |
| addr | input | ADDR_W | Register address |
| wr | input | 1 | Write strobe for an enable mask |
| wdata | input | 6 | Write data |
| rd | input | 1 | Read strobe; clears the addressed event register |
| rdata | output | RD_W | Read data, zero-extended |
| opstat | output | 16 | Operation status summary word |

## Verification
Each source is driven with isolated rising edges and isolated falling edges. This shows that only the intended bit responds and that each direction of a level signal has its own bit. Repeated reads tell the sticky behaviour apart from clear-on-read. A read is also timed so that a new edge is captured on the clearing edge, which exposes a clear that wins over a set. The summary bits are tested with one bit enabled and with a different bit enabled, and the acquisition gate is switched on and off. These show that the masks act on each bit and not on the whole register. A relock is issued both while locked and while unlocked, which separates suppression from a lock path that does nothing at all.

// File: rtl/evstat_pkg.sv
package evstat_pkg;
    // event register widths
    localparam int ACQ_W = 1;
    localparam int CR_W  = 6;
    localparam int LT_W  = 2;
    localparam int JIT_W = 3;

    // synchronised source vector layout
    localparam int S_ACQ   = 0;
    localparam int S_LOCK  = 1;
    localparam int S_RX1   = 2;
    localparam int S_RX2   = 3;
    localparam int S_LTD   = 4;
    localparam int S_LTF   = 5;
    localparam int S_JEF   = 6;
    localparam int S_JSL   = 7;
    localparam int S_JAS   = 8;
    localparam int NSRC    = 9;

    // operation status word
    localparam int OPS_W     = 16;
    localparam int OPS_CLCK  = 7;
    localparam int OPS_LTEST = 8;
    localparam int OPS_ACQ   = 9;
    localparam int OPS_JIT   = 12;

    // register addresses
    localparam int A_ACQ_EV = 0;
    localparam int A_CR_EV  = 1;
    localparam int A_LT_EV  = 2;
    localparam int A_JIT_EV = 3;
    localparam int A_ACQ_EN = 4;
    localparam int A_CR_EN  = 5;
    localparam int A_LT_EN  = 6;
    localparam int A_JIT_EN = 7;

    typedef struct packed {
        logic suppress;
    } top_state_t;
endpackage

// File: rtl/evstat_sync.sv
module evstat_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] s1_d, s1_q, s2_d, s2_q, s3_d, s3_q;

    always_comb begin
        s1_d = async_i;
        s2_d = s1_q;
        s3_d = s2_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
            s3_q <= s3_d;
        end
    end

    assign level_o = s2_q;
    assign rise_o  = s2_q & ~s3_q;
    assign fall_o  = ~s2_q & s3_q;
endmodule

// File: rtl/evstat_evreg.sv
module evstat_evreg #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         rd_clr_i,
    input  logic         en_wr_i,
    input  logic [W-1:0] en_wdata_i,
    output logic [W-1:0] ev_o,
    output logic [W-1:0] en_o,
    output logic         hit_o
);
    logic [W-1:0] ev_d, ev_q, en_d, en_q;

    always_comb begin
        // a set in the clearing cycle survives the clear
        ev_d = (rd_clr_i ? '0 : ev_q) | set_i;
        en_d = en_wr_i ? en_wdata_i : en_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q <= '0;
            en_q <= '0;
        end else begin
            ev_q <= ev_d;
            en_q <= en_d;
        end
    end

    assign ev_o  = ev_q;
    assign en_o  = en_q;
    assign hit_o = |(ev_q & en_q);
endmodule

// File: rtl/evstat_bank.sv
module evstat_bank
    import evstat_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int RD_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acq_done,
    input  logic              cr_locked,
    input  logic              rx1_sig,
    input  logic              rx2_sig,
    input  logic              lt_done,
    input  logic              lt_fail,
    input  logic              jit_edge_fail,
    input  logic              jit_sync_lost,
    input  logic              jit_autoscale,
    input  logic              relock_req,
    input  logic              relock_done,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [CR_W-1:0]   wdata,
    input  logic              rd,
    output logic [RD_W-1:0]   rdata,
    output logic [OPS_W-1:0]  opstat
);
    localparam int NREG = 4;

    logic [NSRC-1:0] src, lvl, rise, fall;
    top_state_t st_d, st_q;

    logic [ACQ_W-1:0] acq_set, acq_ev, acq_en;
    logic [CR_W-1:0]  cr_set, cr_ev, cr_en;
    logic [LT_W-1:0]  lt_set, lt_ev, lt_en;
    logic [JIT_W-1:0] jit_set, jit_ev, jit_en;
    logic [NREG-1:0]  rd_clr, en_wr;
    logic acq_hit, cr_hit, lt_hit, jit_hit;
    logic unused_ok;

    assign src = {jit_autoscale, jit_sync_lost, jit_edge_fail, lt_fail, lt_done,
                  rx2_sig, rx1_sig, cr_locked, acq_done};

    evstat_sync #(.W(NSRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(src),
        .level_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    // bits without a consumer
    assign unused_ok = ^{lvl[NSRC-1:S_RX1], lvl[S_ACQ], fall[NSRC-1:S_LTD], fall[S_ACQ]};

    // strobe decode per register group
    generate
        for (genvar g = 0; g < NREG; g++) begin : g_dec
            assign rd_clr[g] = rd && (int'(addr) == A_ACQ_EV + g);
            assign en_wr[g]  = wr && (int'(addr) == A_ACQ_EN + g);
        end
    endgenerate

    // relock suppression state
    always_comb begin
        st_d = st_q;
        if (relock_done)
            st_d.suppress = 1'b0;
        else if (relock_req && lvl[S_LOCK])
            st_d.suppress = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // set vectors
    always_comb begin
        acq_set    = rise[S_ACQ];
        cr_set[0]  = fall[S_LOCK] & ~st_q.suppress;
        cr_set[1]  = rise[S_LOCK] & ~st_q.suppress;
        cr_set[2]  = fall[S_RX1];
        cr_set[3]  = rise[S_RX1];
        cr_set[4]  = fall[S_RX2];
        cr_set[5]  = rise[S_RX2];
        lt_set     = {rise[S_LTF], rise[S_LTD]};
        jit_set    = {rise[S_JAS], rise[S_JSL], rise[S_JEF]};
    end

    evstat_evreg #(.W(ACQ_W)) u_acq (
        .clk(clk), .rst_n(rst_n), .set_i(acq_set), .rd_clr_i(rd_clr[0]),
        .en_wr_i(en_wr[0]), .en_wdata_i(wdata[ACQ_W-1:0]),
        .ev_o(acq_ev), .en_o(acq_en), .hit_o(acq_hit)
    );
    evstat_evreg #(.W(CR_W)) u_cr (
        .clk(clk), .rst_n(rst_n), .set_i(cr_set), .rd_clr_i(rd_clr[1]),
        .en_wr_i(en_wr[1]), .en_wdata_i(wdata[CR_W-1:0]),
        .ev_o(cr_ev), .en_o(cr_en), .hit_o(cr_hit)
    );
    evstat_evreg #(.W(LT_W)) u_lt (
        .clk(clk), .rst_n(rst_n), .set_i(lt_set), .rd_clr_i(rd_clr[2]),
        .en_wr_i(en_wr[2]), .en_wdata_i(wdata[LT_W-1:0]),
        .ev_o(lt_ev), .en_o(lt_en), .hit_o(lt_hit)
    );
    evstat_evreg #(.W(JIT_W)) u_jit (
        .clk(clk), .rst_n(rst_n), .set_i(jit_set), .rd_clr_i(rd_clr[3]),
        .en_wr_i(en_wr[3]), .en_wdata_i(wdata[JIT_W-1:0]),
        .ev_o(jit_ev), .en_o(jit_en), .hit_o(jit_hit)
    );

    // summary word
    always_comb begin
        opstat            = '0;
        opstat[OPS_CLCK]  = cr_hit;
        opstat[OPS_LTEST] = lt_hit;
        opstat[OPS_ACQ]   = acq_hit | (lt_ev[0] & acq_en[0]);
        opstat[OPS_JIT]   = jit_hit;
    end

    // read mux
    always_comb begin
        rdata = '0;
        case (int'(addr))
            A_ACQ_EV: rdata[ACQ_W-1:0] = acq_ev;
            A_CR_EV:  rdata[CR_W-1:0]  = cr_ev;
            A_LT_EV:  rdata[LT_W-1:0]  = lt_ev;
            A_JIT_EV: rdata[JIT_W-1:0] = jit_ev;
            A_ACQ_EN: rdata[ACQ_W-1:0] = acq_en;
            A_CR_EN:  rdata[CR_W-1:0]  = cr_en;
            A_LT_EN:  rdata[LT_W-1:0]  = lt_en;
            A_JIT_EN: rdata[JIT_W-1:0] = jit_en;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/evstat_chk.sv
module evstat_chk
    import evstat_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd,
    input logic [ADDR_W-1:0] addr,
    input logic [OPS_W-1:0]  opstat,
    input logic [CR_W-1:0]   cr_ev,
    input logic [CR_W-1:0]   cr_set,
    input logic [ACQ_W-1:0]  acq_en,
    input logic              sup
);
    logic cr_read;
    assign cr_read = rd && (int'(addr) == A_CR_EV);

    // R5: without a read, no clock recovery bit falls
    p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cr_read |=> ((cr_ev & $past(cr_ev)) == $past(cr_ev)));

    // R5: after a read only newly captured bits remain
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cr_read |=> ((cr_ev & ~$past(cr_set)) == '0));

    // R9: while suppressed, lock and unlock bits gain nothing
    p_relock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sup |=> ((cr_ev[1:0] & ~$past(cr_ev[1:0])) == 2'b00));

    // R8: the ACQ summary bit needs its enable
    p_acq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        opstat[OPS_ACQ] |-> acq_en[0]);

    // R7: unassigned summary bits stay low
    p_ops_spare_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (opstat & ~16'h1380) == '0);
endmodule

bind evstat_bank evstat_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd(rd), .addr(addr), .opstat(opstat),
    .cr_ev(cr_ev), .cr_set(cr_set), .acq_en(acq_en), .sup(st_q.suppress)
);

// File: tb/evstat_bank_test.sv
`timescale 1ns/1ps
module evstat_bank_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acq_done = 0, cr_locked = 0, rx1_sig = 0, rx2_sig = 0;
    logic lt_done = 0, lt_fail = 0, jit_edge_fail = 0, jit_sync_lost = 0, jit_autoscale = 0;
    logic relock_req = 0, relock_done = 0;
    logic [2:0] addr = '0;
    logic wr = 0, rd = 0;
    logic [5:0] wdata = '0;
    logic [15:0] rdata, opstat;

    int errors = 0;
    int checks = 0;
    logic [15:0] v;

    always #10 clk = ~clk;

    evstat_bank uut (
        .clk(clk), .rst_n(rst_n), .acq_done(acq_done), .cr_locked(cr_locked),
        .rx1_sig(rx1_sig), .rx2_sig(rx2_sig), .lt_done(lt_done), .lt_fail(lt_fail),
        .jit_edge_fail(jit_edge_fail), .jit_sync_lost(jit_sync_lost),
        .jit_autoscale(jit_autoscale), .relock_req(relock_req), .relock_done(relock_done),
        .addr(addr), .wr(wr), .wdata(wdata), .rd(rd), .rdata(rdata), .opstat(opstat)
    );

    task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_reg(input logic [2:0] a, output logic [15:0] d);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [5:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic t_reset;
        for (int a = 0; a < 8; a++) begin
            read_reg(3'(a), v);
            check($sformatf("R10 reset reg %0d", a), v, 16'h0);
        end
        check("R10 reset opstat", opstat, 16'h0);
    endtask

    task automatic t_acq;
        acq_done = 1; step(2);
        check("R1 not yet at two cycles", 16'(uut.rdata), 16'h0);
        step(2); acq_done = 0;
        read_reg(0, v); check("R1 acq bit0", v, 16'h1);
        read_reg(0, v); check("R5 acq cleared by read", v, 16'h0);
    endtask

    task automatic t_lock;
        cr_locked = 1; step(4);
        read_reg(1, v); check("R2 lock rise bit1", v, 16'h2);
        cr_locked = 0; step(4);
        read_reg(1, v); check("R2 lock fall bit0", v, 16'h1);
    endtask

    task automatic t_rx;
        rx1_sig = 1; step(4);
        read_reg(1, v); check("R3 rx1 rise bit3", v, 16'h8);
        step(4);
        read_reg(1, v); check("R3 steady level sets nothing", v, 16'h0);
        rx1_sig = 0; step(4);
        read_reg(1, v); check("R3 rx1 fall bit2", v, 16'h4);
        rx2_sig = 1; step(4);
        rx2_sig = 0; step(4);
        read_reg(1, v); check("R3 rx2 both edges bits5,4 sticky R5", v, 16'h30);
    endtask

    task automatic pulse_wait(ref logic s);
        s = 1; step(2); s = 0; step(3);
    endtask

    task automatic t_lt_jit;
        pulse_wait(lt_done);
        read_reg(2, v); check("R4 lt done bit0", v, 16'h1);
        pulse_wait(lt_fail);
        read_reg(2, v); check("R4 lt fail bit1", v, 16'h2);
        pulse_wait(jit_edge_fail);
        read_reg(3, v); check("R4 jit edge bit0", v, 16'h1);
        pulse_wait(jit_sync_lost);
        read_reg(3, v); check("R4 jit sync bit1", v, 16'h2);
        pulse_wait(jit_autoscale);
        read_reg(3, v); check("R4 jit autoscale bit2", v, 16'h4);
    endtask

    task automatic t_collision;
        pulse_wait(lt_done);
        lt_fail = 1; step(2);
        read_reg(2, v); check("R5 read value before collision", v, 16'h1);
        read_reg(2, v); check("R5 event on clearing edge kept", v, 16'h2);
        lt_fail = 0; step(4);
        read_reg(2, v); check("R5 register empty afterwards", v, 16'h0);
    endtask

    task automatic t_enables;
        write_reg(5, 6'h2A);
        read_reg(5, v); check("R6 cr enable readback", v, 16'h2A);
        read_reg(5, v); check("R6 enable not cleared by read", v, 16'h2A);
        write_reg(4, 6'h3F);
        read_reg(4, v); check("R6 acq enable width", v, 16'h1);
        write_reg(7, 6'h3F);
        read_reg(7, v); check("R6 jit enable width", v, 16'h7);
        write_reg(1, 6'h3F);
        read_reg(1, v); check("R6 write to event reg ignored", v, 16'h0);
        write_reg(4, 6'h0);
        write_reg(7, 6'h0);
    endtask

    task automatic t_summary;
        write_reg(5, 6'h04);
        rx1_sig = 1; step(4);
        check("R7 clck masked", opstat, 16'h0);
        rx1_sig = 0; step(4);
        check("R7 clck enabled bit", opstat, 16'h0080);
        read_reg(1, v); check("R7 cr contents", v, 16'h0C);
        check("R7 clck clears with read", opstat, 16'h0);
        write_reg(6, 6'h02);
        pulse_wait(lt_done);
        check("R8 acq gated off", opstat, 16'h0);
        write_reg(4, 6'h01);
        check("R8 acq from limit test done", opstat, 16'h0200);
        pulse_wait(lt_fail);
        check("R7 ltest enabled", opstat, 16'h0300);
        read_reg(2, v);
        check("R8 acq clears with lt read", opstat, 16'h0);
        pulse_wait(acq_done);
        check("R8 acq from acquisition event", opstat, 16'h0200);
        read_reg(0, v);
        write_reg(7, 6'h04);
        pulse_wait(jit_sync_lost);
        check("R7 jit masked bit", opstat, 16'h0);
        pulse_wait(jit_autoscale);
        check("R7 jit enabled", opstat, 16'h1000);
        read_reg(3, v);
        write_reg(4, 6'h0);
    endtask

    task automatic t_relock;
        cr_locked = 1; step(4);
        read_reg(1, v);
        relock_req = 1; step(1); relock_req = 0;
        cr_locked = 0; step(4);
        cr_locked = 1; step(5);
        relock_done = 1; step(1); relock_done = 0;
        read_reg(1, v); check("R9 relock while locked silent", v, 16'h0);
        cr_locked = 0; step(4);
        read_reg(1, v); check("R9 unlock after relock reported", v, 16'h1);
        relock_req = 1; step(1); relock_req = 0;
        cr_locked = 1; step(4);
        read_reg(1, v); check("R9 relock while unlocked not suppressed", v, 16'h2);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset;
        t_acq;
        t_lock;
        t_rx;
        t_lt_jit;
        t_collision;
        t_enables;
        t_summary;
        t_relock;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule